// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. Software reaches it through a small byte-wide register port. It holds the input channel, the choice of each reference, the divide ratio of the conversion clock, an enable, a start/busy bit, a sticky completion flag with its interrupt enable, and a 16-bit result pair. The block derives a conversion-clock tick from the system clock. It drives the channel number to an external analog multiplexer and asks for sampling during a fixed acquisition window. It then presents trial codes to an external DAC/comparator pair, one bit per tick, starting with the most significant bit.

A conversion starts when software sets the start bit. When the last bit has been resolved, the block writes the result, drops the busy bit and raises the flag, all on one clock edge. Software can then poll or take the interrupt. The block then waits for a recovery gap before it accepts a new start. Clearing the start bit in the middle of a conversion abandons it and leaves the earlier result in place.

Register map (byte address on `addr`). Address 0 is control: bit 0 enable, bit 2 start/busy, bits 5:3 channel, bits 7:6 clock divider select, bit 1 reads 0. Address 1 is configuration: bit 0 external positive reference, bit 1 external negative reference, bit 2 right-justify, bit 3 interrupt enable, bit 4 completion flag, bits 7:5 read 0. Address 2 is the result high byte and address 3 the result low byte, both read-only.

Top module: `adc_seq`

## Requirements
- R1: A control write with bit 0 = 1 and bit 2 = 1 while the block is idle starts a conversion; from the next cycle control bit 2 reads 1 until the conversion ends or is aborted. After reset every register reads 0 and `irq` and `sample_en` are 0.
- R2: On completion the result pair is written, control bit 2 clears and configuration bit 4 sets on the same clock edge. With ACQ_TAD = 2 this edge is exactly 12 × divide-ratio clock edges after the edge that took the start write.
- R3: The result is 10 bits, resolved MSB first with one bit per tick. `dac_code` shows the trial code, and `cmp_in` = 1 (input ≥ trial) keeps the trial bit. With an ideal comparator the result equals the input code, including 0 and 1023.
- R4: With configuration bit 2 = 1 the pair holds {6'b0, result} (high byte = bits 15:8). With bit 2 = 0 it holds {result, 6'b0}. The choice is taken at the moment of completion.
- R5: `irq` is 1 exactly when the flag (configuration bit 4) and the interrupt enable (configuration bit 3) are both 1. Writing 0 to bit 4 clears the flag. Writing 1 to it does not set it.
- R6: Control bits 7:6 select the conversion-clock ratio: 00 gives 2, 01 gives 8, 10 and 11 give 32. While enabled, `tad_tick` is high for one cycle in each period.
- R7: Control bits 5:3 drive `chan_sel`. Configuration bit 0 drives `vref_pos_ext` and bit 1 drives `vref_neg_ext`.
- R8: A start write made within RECOV_TAD (2) ticks after completion is ignored, and control bit 2 stays 0. A start write made after the gap is accepted.
- R9: A start write whose enable bit (control bit 0) is 0 is ignored. Control bit 2 stays 0 and no sampling begins.
- R10: A control write with bit 2 = 0 or bit 0 = 0 during a conversion aborts it. The result pair keeps its old value, the flag is not set, and a new start is accepted at once.
- R11: `sample_en` is 1 for exactly ACQ_TAD ticks after an accepted start and is 0 while bits are being resolved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cmp_in | input | 1 | Comparator result: 1 when input ≥ trial code |
| dac_code | output | 10 | Trial code for the comparator DAC |
| chan_sel | output | 3 | Analog multiplexer channel |
| vref_pos_ext | output | 1 | Use the external positive reference |
| vref_neg_ext | output | 1 | Use the external negative reference |
| sample_en | output | 1 | Sample-and-hold tracks the input |
| tad_tick | output | 1 | One-cycle conversion-clock tick |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `cmp_in` is settled by the cycle in which a tick resolves a bit. They also assume that software never changes the divider select while a start is being taken. The bench holds these conditions by computing the comparator combinationally from `dac_code` and a fixed per-channel input value, and by writing the divider select in the same control write that starts the conversion. A fixed input value per channel also keeps the SAR result equal to that value, which the scoreboard predicts. Writes come only from single-cycle bus tasks, so a start and an abort never fall in the same cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_CONV  = 2'd2,
        ST_RECOV = 2'd3
    } seq_st_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_RESH = 2'd2;
    localparam logic [1:0] A_RESL = 2'd3;

endpackage

// File: rtl/adc_tad_div.sv
module adc_tad_div #(
    parameter int LOG2_A = 1,
    parameter int LOG2_B = 3,
    parameter int LOG2_C = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int CW = LOG2_C;

    logic [CW-1:0] cnt_d, cnt_q, lim;
    logic          wrap;

    always_comb begin
        case (sel)
            2'd0:    lim = CW'((1 << LOG2_A) - 1);
            2'd1:    lim = CW'((1 << LOG2_B) - 1);
            default: lim = CW'((1 << LOG2_C) - 1);
        endcase
    end

    assign wrap = (cnt_q >= lim);
    assign tick = en && !restart && wrap;

    always_comb begin
        if (!en || restart || wrap) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: a tick never lasts more than one cycle
    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/adc_sar_step.sv
module adc_sar_step #(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp,
    output logic [NBITS-1:0] code,
    output logic             last,
    output logic [NBITS-1:0] result
);
    localparam int IW = $clog2(NBITS);

    typedef struct packed {
        logic [NBITS-1:0] code;
        logic [IW-1:0]    idx;
    } sar_s;

    sar_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.code = NBITS'(1) << (NBITS - 1);
            s_d.idx  = IW'(NBITS - 1);
        end else if (step) begin
            s_d.code[s_q.idx] = cmp;
            if (s_q.idx != '0) begin
                s_d.code[s_q.idx - 1'b1] = 1'b1;
                s_d.idx = s_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign code   = s_q.code;
    assign last   = (s_q.idx == '0);
    assign result = {s_q.code[NBITS-1:1], cmp};

    // R3: every non-final step moves one bit down and raises the next trial bit
    p_idx_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !last) |=> (s_q.idx == $past(s_q.idx) - 1'b1) && s_q.code[s_q.idx]);

    // R3: loading and stepping never coincide
    p_no_load_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
    parameter int NBITS     = 10,
    parameter int ACQ_TAD   = 2,
    parameter int RECOV_TAD = 2,
    parameter int DIV_LOG2A = 1,
    parameter int DIV_LOG2B = 3,
    parameter int DIV_LOG2C = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             cmp_in,
    output logic [NBITS-1:0] dac_code,
    output logic [2:0]       chan_sel,
    output logic             vref_pos_ext,
    output logic             vref_neg_ext,
    output logic             sample_en,
    output logic             tad_tick,
    output logic             irq
);
    import adc_seq_pkg::*;

    localparam int RES_W = 16;
    localparam int MAXW  = (ACQ_TAD > RECOV_TAD) ? ACQ_TAD : RECOV_TAD;
    localparam int CW    = $clog2(MAXW + 1);

    typedef struct packed {
        seq_st_e          st;
        logic             en;
        logic [2:0]       chan;
        logic [1:0]       dsel;
        logic [1:0]       vref;
        logic             rjust;
        logic             ie;
        logic             flag;
        logic [RES_W-1:0] res;
        logic [CW-1:0]    cnt;
    } seq_s;

    seq_s q, n;

    logic             tick, wr_ctrl, wr_cfg, start_go, busy, abort;
    logic             sar_load, sar_step, sar_last, done;
    logic [NBITS-1:0] sar_res;
    logic             unused_bits;

    assign unused_bits = ^{wdata[7:5], wdata[1]};

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_cfg   = wr_en && (addr == A_CFG);
    assign busy     = (q.st == ST_ACQ) || (q.st == ST_CONV);
    assign start_go = wr_ctrl && wdata[2] && wdata[0] && (q.st == ST_IDLE);
    assign abort    = wr_ctrl && busy && (!wdata[2] || !wdata[0]);
    assign sar_load = (q.st == ST_ACQ) && !abort && tick && (q.cnt == CW'(ACQ_TAD - 1));
    assign sar_step = (q.st == ST_CONV) && !abort && tick;
    assign done     = sar_step && sar_last;

    adc_tad_div #(
        .LOG2_A(DIV_LOG2A),
        .LOG2_B(DIV_LOG2B),
        .LOG2_C(DIV_LOG2C)
    ) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (q.en),
        .restart(start_go),
        .sel    (q.dsel),
        .tick   (tick)
    );

    adc_sar_step #(
        .NBITS(NBITS)
    ) sar_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sar_load),
        .step  (sar_step),
        .cmp   (cmp_in),
        .code  (dac_code),
        .last  (sar_last),
        .result(sar_res)
    );

    always_comb begin
        n = q;
        if (wr_ctrl) begin
            n.en   = wdata[0];
            n.chan = wdata[5:3];
            n.dsel = wdata[7:6];
        end
        if (wr_cfg) begin
            n.vref  = wdata[1:0];
            n.rjust = wdata[2];
            n.ie    = wdata[3];
            if (!wdata[4]) n.flag = 1'b0;
        end
        case (q.st)
            ST_IDLE: begin
                if (start_go) begin
                    n.st  = ST_ACQ;
                    n.cnt = '0;
                end
            end
            ST_ACQ: begin
                if (abort) n.st = ST_IDLE;
                else if (sar_load) begin
                    n.st  = ST_CONV;
                    n.cnt = '0;
                end else if (tick) n.cnt = q.cnt + 1'b1;
            end
            ST_CONV: begin
                if (abort) n.st = ST_IDLE;
                else if (done) begin
                    n.st   = ST_RECOV;
                    n.cnt  = '0;
                    n.flag = 1'b1;
                    n.res  = q.rjust ? RES_W'(sar_res)
                                     : (RES_W'(sar_res) << (RES_W - NBITS));
                end
            end
            default: begin
                if (tick) begin
                    if (q.cnt == CW'(RECOV_TAD - 1)) n.st = ST_IDLE;
                    else                             n.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {q.dsel, q.chan, busy, 1'b0, q.en};
            A_CFG:   rdata = {3'b000, q.flag, q.ie, q.rjust, q.vref};
            A_RESH:  rdata = q.res[15:8];
            default: rdata = q.res[7:0];
        endcase
    end

    assign chan_sel     = q.chan;
    assign vref_pos_ext = q.vref[0];
    assign vref_neg_ext = q.vref[1];
    assign sample_en    = (q.st == ST_ACQ);
    assign tad_tick     = tick;
    assign irq          = q.flag && q.ie;

    // R2: the flag only rises on the edge that ends a busy period
    p_flag_with_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> $fell(busy));

    // R10: a busy period that ends without entering recovery keeps the result
    p_abort_keeps_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && (q.st != ST_RECOV)) |-> $stable(q.res));

    // R9: no conversion activity while disabled
    p_busy_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> q.en);

    // R1: sampling only ever begins from idle
    p_acq_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_en) |-> ($past(q.st) == ST_IDLE));

    // R8: recovery never leads straight into a new acquisition
    p_no_start_in_recov_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RECOV) |=> (q.st != ST_ACQ));

endmodule

// File: tb/adc_seq_tb_top.sv
module adc_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [2:0] chan_sel;
    logic       vref_pos_ext, vref_neg_ext, sample_en, tad_tick, irq;

    logic [9:0] vin [0:7];

    int total = 0;
    int bad   = 0;

    logic [15:0] exp_q [$];
    logic [15:0] obs_val;
    event        obs_ev;

    always #10 clk = ~clk;

    assign cmp_in = (vin[chan_sel] >= dac_code);

    adc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel),
        .vref_pos_ext(vref_pos_ext), .vref_neg_ext(vref_neg_ext),
        .sample_en(sample_en), .tad_tick(tad_tick), .irq(irq)
    );

    task automatic check(input string tag, input int got, input int expv);
        total++;
        if (got != expv) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, expv);
        end
    endtask

    function automatic logic [7:0] ctrlb(input logic en, input logic go,
                                         input logic [2:0] ch, input logic [1:0] ds);
        return {ds, ch, go, 1'b0, en};
    endfunction

    function automatic logic [7:0] cfgb(input logic [1:0] vr, input logic rj,
                                        input logic ie, input logic fk);
        return {3'b000, fk, ie, rj, vr};
    endfunction

    function automatic int divof(input logic [1:0] ds);
        return (ds == 2'd0) ? 2 : (ds == 2'd1) ? 8 : 32;
    endfunction

    function automatic logic [15:0] fmt(input logic [9:0] v, input logic rj);
        return rj ? {6'b0, v} : {v, 6'b0};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic launch(input logic [2:0] ch, input logic [1:0] ds, input logic rj);
        exp_q.push_back(fmt(vin[ch], rj));
        wr(2'd1, cfgb(2'b00, rj, 1'b1, 1'b0));
        wr(2'd0, ctrlb(1'b1, 1'b1, ch, ds));
    endtask

    task automatic collect(input logic [1:0] ds);
        int n = 0;
        logic [7:0] h, l;
        while (!irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R2 latency in clocks", n, 12 * divof(ds));
        rd(2'd2, h);
        rd(2'd3, l);
        obs_val = {h, l};
        -> obs_ev;
        wr(2'd1, cfgb(2'b00, 1'b1, 1'b1, 1'b0));
        check("R5 irq low after flag clear", irq, 0);
        repeat (2 * divof(ds) + 2) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3/R4 scoreboard: got 0x%0h expected nothing", obs_val);
            end else begin
                check("R3/R4 scoreboard result", obs_val, exp_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, h, l;
        int ticks;
        int ch_l [6] = '{0, 6, 1, 4, 5, 7};
        int ds_l [6] = '{0, 1, 2, 0, 1, 2};
        int rj_l [6] = '{1, 1, 0, 1, 0, 0};

        vin[0] = 10'd0;   vin[1] = 10'd512; vin[2] = 10'h2A5; vin[3] = 10'd100;
        vin[4] = 10'd511; vin[5] = 10'd341; vin[6] = 10'd1023; vin[7] = 10'h1C3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, d); check("R1 reset ctrl", d, 0);
        rd(2'd1, d); check("R1 reset cfg", d, 0);
        rd(2'd2, d); check("R1 reset resh", d, 0);
        check("R1 reset irq", irq, 0);
        check("R1 reset sample_en", sample_en, 0);

        // R7: channel and reference outputs
        wr(2'd0, ctrlb(1'b0, 1'b0, 3'd5, 2'd0));
        check("R7 chan_sel", chan_sel, 5);
        wr(2'd1, cfgb(2'b01, 1'b0, 1'b0, 1'b0));
        check("R7 vref_pos_ext", vref_pos_ext, 1);
        check("R7 vref_neg_ext", vref_neg_ext, 0);
        wr(2'd1, cfgb(2'b10, 1'b0, 1'b0, 1'b0));
        check("R7 vref_pos_ext off", vref_pos_ext, 0);
        check("R7 vref_neg_ext on", vref_neg_ext, 1);

        // R9: start while disabled is ignored
        wr(2'd0, ctrlb(1'b0, 1'b1, 3'd5, 2'd0));
        rd(2'd0, d); check("R9 start bit stays 0", d[2], 0);
        repeat (20) @(negedge clk);
        check("R9 no sampling", sample_en, 0);
        rd(2'd1, d); check("R9 flag stays 0", d[4], 0);

        // R6: tick rates
        for (int s = 0; s < 3; s++) begin
            wr(2'd0, ctrlb(1'b1, 1'b0, 3'd0, 2'(s)));
            ticks = 0;
            for (int k = 0; k < 64; k++) begin
                @(negedge clk);
                if (tad_tick) ticks++;
            end
            check("R6 ticks per 64 clocks", ticks, 64 / divof(2'(s)));
        end

        // R2, R3, R4, R11: polled conversion, right justified, ratio 2
        wr(2'd1, cfgb(2'b00, 1'b1, 1'b0, 1'b0));
        wr(2'd0, ctrlb(1'b1, 1'b1, 3'd2, 2'd0));
        rd(2'd0, d); check("R1 busy after start", d[2], 1);
        check("R11 sampling after start", sample_en, 1);
        for (int k = 1; k < 24; k++) begin
            @(negedge clk);
            if (k == 3) check("R11 sampling at end of window", sample_en, 1);
            if (k == 4) check("R11 sampling off in conversion", sample_en, 0);
        end
        rd(2'd1, d); check("R2 flag 0 one clock before end", d[4], 0);
        @(negedge clk);
        rd(2'd1, d); check("R2 flag set at end", d[4], 1);
        check("R5 irq stays 0 with enable off", irq, 0);
        rd(2'd0, d); check("R2 busy clear at end", d[2], 0);
        rd(2'd2, h); rd(2'd3, l);
        check("R3 R4 right-justified result", {h, l}, 16'h02A5);

        // R8: start inside the recovery gap is dropped
        wr(2'd0, ctrlb(1'b1, 1'b1, 3'd2, 2'd0));
        rd(2'd0, d); check("R8 start in gap ignored", d[2], 0);
        repeat (10) @(negedge clk);
        check("R8 no sampling after dropped start", sample_en, 0);
        wr(2'd0, ctrlb(1'b1, 1'b1, 3'd2, 2'd0));
        rd(2'd0, d); check("R8 start after gap accepted", d[2], 1);
        for (int k = 0; k < 200 && d[2]; k++) begin
            @(negedge clk);
            rd(2'd0, d);
        end
        rd(2'd2, h); rd(2'd3, l);
        check("R3 second conversion result", {h, l}, 16'h02A5);

        // R5: flag sticky and write-one ignored
        wr(2'd1, cfgb(2'b00, 1'b1, 1'b0, 1'b1));
        rd(2'd1, d); check("R5 flag sticky", d[4], 1);
        check("R5 irq masked", irq, 0);
        wr(2'd1, cfgb(2'b00, 1'b1, 1'b1, 1'b1));
        check("R5 irq with flag and enable", irq, 1);
        wr(2'd1, cfgb(2'b00, 1'b1, 1'b1, 1'b0));
        rd(2'd1, d); check("R5 flag cleared by zero", d[4], 0);
        wr(2'd1, cfgb(2'b00, 1'b1, 1'b0, 1'b1));
        rd(2'd1, d); check("R5 writing one does not set flag", d[4], 0);

        // R10: abort mid-conversion
        repeat (8) @(negedge clk);
        wr(2'd0, ctrlb(1'b1, 1'b1, 3'd3, 2'd0));
        repeat (10) @(negedge clk);
        wr(2'd0, ctrlb(1'b1, 1'b0, 3'd3, 2'd0));
        rd(2'd0, d); check("R10 busy cleared by abort", d[2], 0);
        repeat (60) @(negedge clk);
        rd(2'd1, d); check("R10 flag not set", d[4], 0);
        rd(2'd2, h); rd(2'd3, l);
        check("R10 result unchanged", {h, l}, 16'h02A5);
        wr(2'd0, ctrlb(1'b1, 1'b1, 3'd3, 2'd0));
        rd(2'd0, d); check("R10 restart accepted at once", d[2], 1);
        for (int k = 0; k < 200 && d[2]; k++) begin
            @(negedge clk);
            rd(2'd0, d);
        end
        rd(2'd2, h); rd(2'd3, l);
        check("R3 result after abort and restart", {h, l}, 16'h0064);
        repeat (8) @(negedge clk);

        // scoreboard: interrupt-driven runs over channels, ratios and alignments
        for (int i = 0; i < 6; i++) begin
            launch(3'(ch_l[i]), 2'(ds_l[i]), 1'(rj_l[i]));
            collect(2'(ds_l[i]));
        end
        repeat (4) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule